// File: doc/BRIEF.md
# Flash Program/Erase Host Sequencer

This block sits on the host side of a 16-bit asynchronous NOR-style flash device. It takes one request at a time over a valid/ready handshake: program one word, erase a sector, erase a block or erase the whole chip. It then drives the complete unlock-and-command write sequence on the flash bus. Each bus cycle is shaped from three programmable clock counts: setup, strobe and hold.

Once the last command write is out, the block switches to read cycles on the target address. It watches the status bits until the device reports that its internal operation has finished. It can watch either the complemented data bit 7 or the alternating bit 6; a static configuration input selects which. The device finishes at a time the host cannot predict, so a read that looks finished is not trusted alone. Two further reads must return the expected word before a one-cycle `done` pulse is raised. If the operation never finishes within a parameterised number of reads, a one-cycle `err` pulse is raised instead.

The data bus is modelled as a tristate pad: an output value, an output-enable and an input value.

Top module: `flash_seq_top`

## Requirements
- R1: A program request (`req_op` = 0) issues exactly four write cycles in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then `req_data` at `req_addr`.
- R2: An erase request issues exactly six write cycles. The first five are AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. The sixth is 30h at `req_addr` for sector erase (`req_op` = 1), 50h at `req_addr` for block erase (`req_op` = 2), or 10h at 5555h for chip erase (`req_op` = 3).
- R3: Every bus cycle holds `fl_ce_n` low throughout and consists of three phases. First come `t_setup` cycles with the strobe high, then `t_pulse` cycles with the strobe low, then `t_hold` cycles with the strobe high. A count of 0 behaves as 1. `fl_ce_n` returns high between bus cycles.
- R4: During a write cycle `fl_dq_oe` is 1 for the whole cycle, and `fl_addr` and `fl_dq_out` do not change while `fl_we_n` is low. `fl_we_n` is never low while `fl_ce_n` is high.
- R5: During a read cycle `fl_dq_oe` is 0, `fl_we_n` stays high, and `fl_oe_n` is low only during the strobe phase. `fl_we_n` and `fl_oe_n` are never low together.
- R6: After the last write, reads go to `req_addr`. With `cfg_toggle` = 0, a read shows completion when its bit 7 equals the expected bit: bit 7 of `req_data` for a program, 1 for any erase.
- R7: With `cfg_toggle` = 1, a read shows completion when its bit 6 equals bit 6 of the previous status read. The first read after the last write never shows completion.
- R8: After a read that shows completion, two more reads follow. The expected word is `req_data` for a program and FFFFh for an erase. `done` pulses for one cycle only if both reads return the expected word. A mismatch sends the block back to polling.
- R9: If `POLL_LIMIT` status reads pass without `done`, `err` pulses for one cycle on the last of them and the block returns to idle.
- R10: `req_ready` is 1 exactly while the block is idle. A request is taken when `req_valid` and `req_ready` are both 1. A request raised while the block is busy produces no bus activity.
- R11: After reset `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_dq_oe` is 0, `req_ready` is 1, and `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | 16 | Word to program |
| cfg_toggle | input | 1 | 0: bit-7 polling, 1: bit-6 toggle polling (static) |
| t_setup | input | CNT_W | Setup phase length in clocks |
| t_pulse | input | CNT_W | Strobe phase length in clocks |
| t_hold | input | CNT_W | Hold phase length in clocks |
| done | output | 1 | One-cycle pulse: operation confirmed complete |
| err | output | 1 | One-cycle pulse: poll limit reached |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_out | output | 16 | Data driven onto the flash bus |
| fl_dq_oe | output | 1 | Data pad output enable |
| fl_dq_in | input | 16 | Data read from the flash bus |

## Verification
A wrong step counter or command decode shows up on the flash bus within the request itself. The captured write log then differs from the expected unlock pattern in address or data, or has the wrong number of entries. A faulty phase counter shows up within one bus cycle, as a measured setup, strobe or hold length that differs from the programmed count. A broken completion or confirmation state shows up only at the end of the request. There it appears as a read count different from the one the device model's busy profile implies, or as `err` in place of `done`. The glitch and timeout vectors are there to expose these cases.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int FL_DW = 16;

    typedef enum logic [1:0] {
        OP_PROGRAM = 2'd0,
        OP_SECTOR  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CHIP    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WRITE,
        SQ_POLL,
        SQ_CONFIRM
    } seq_state_e;

    // One command write: either a fixed key address or the request target.
    typedef struct packed {
        logic        use_target;
        logic [15:0] key_addr;
        logic [15:0] data;
    } step_t;

    localparam logic [15:0] KEY_A = 16'h5555;
    localparam logic [15:0] KEY_B = 16'h2AAA;

    function automatic logic [2:0] last_step(op_e op);
        return (op == OP_PROGRAM) ? 3'd3 : 3'd5;
    endfunction

    function automatic step_t seq_step(op_e op, logic [2:0] idx, logic [15:0] wdata);
        step_t s;
        s.use_target = 1'b0;
        s.key_addr   = KEY_A;
        s.data       = 16'h00AA;
        case (idx)
            3'd0: begin s.key_addr = KEY_A; s.data = 16'h00AA; end
            3'd1: begin s.key_addr = KEY_B; s.data = 16'h0055; end
            3'd2: begin
                s.key_addr = KEY_A;
                s.data     = (op == OP_PROGRAM) ? 16'h00A0 : 16'h0080;
            end
            3'd3: begin
                if (op == OP_PROGRAM) begin
                    s.use_target = 1'b1;
                    s.data       = wdata;
                end else begin
                    s.key_addr = KEY_A;
                    s.data     = 16'h00AA;
                end
            end
            3'd4: begin s.key_addr = KEY_B; s.data = 16'h0055; end
            default: begin
                case (op)
                    OP_SECTOR: begin s.use_target = 1'b1; s.data = 16'h0030; end
                    OP_BLOCK:  begin s.use_target = 1'b1; s.data = 16'h0050; end
                    default:   begin s.key_addr = KEY_A;  s.data = 16'h0010; end
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  t_setup,
    input  logic [CNT_W-1:0]  t_pulse,
    input  logic [CNT_W-1:0]  t_hold,
    input  logic [DATA_W-1:0] dq_in,
    output logic              idle,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    // Remaining-count load value; zero is stretched to one clock.
    function automatic logic [CNT_W-1:0] span_m1(logic [CNT_W-1:0] t);
        return (t == '0) ? '0 : t - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        wr_q    <= wr;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                        cnt     <= span_m1(t_setup);
                        ph      <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        cnt <= span_m1(t_pulse);
                        ph  <= PH_PULSE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == '0) begin
                        if (!wr_q) rdata_q <= dq_in;
                        cnt <= span_m1(t_hold);
                        ph  <= PH_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign idle     = (ph == PH_IDLE);
    assign cyc_done = done_q;
    assign rdata    = rdata_q;
    assign ce_n     = (ph == PH_IDLE);
    assign we_n     = !((ph == PH_PULSE) && wr_q);
    assign oe_n     = !((ph == PH_PULSE) && !wr_q);
    assign bus_addr = addr_q;
    assign dq_out   = wdata_q;
    assign dq_oe    = (ph != PH_IDLE) && wr_q;

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
    parameter int DATA_W = 16
) (
    input  logic              toggle_mode,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] exp_word,
    input  logic              prev_b6,
    input  logic              have_prev,
    output logic              settled,
    output logic              word_ok
);

    logic b7_match;
    logic b6_quiet;

    assign b7_match = (rd_word[7] == exp_word[7]);
    assign b6_quiet = have_prev && (rd_word[6] == prev_b6);
    assign settled  = toggle_mode ? b6_quiet : b7_match;
    assign word_ok  = (rd_word == exp_word);

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int CNT_W      = 4,
    parameter int POLL_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_data,
    input  logic              cfg_toggle,
    input  logic [CNT_W-1:0]  t_setup,
    input  logic [CNT_W-1:0]  t_pulse,
    input  logic [CNT_W-1:0]  t_hold,
    output logic              done,
    output logic              err,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [15:0]       fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [15:0]       fl_dq_in
);

    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam logic [PCW-1:0] PC_LAST = PCW'(POLL_LIMIT - 1);

    seq_state_e        st;
    op_e               op_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [15:0]       wdat_q;
    logic [2:0]        step_q;
    logic              pending;
    logic              prev_b6;
    logic              have_prev;
    logic [PCW-1:0]    poll_cnt;
    logic              conf_cnt;
    logic              done_q;
    logic              err_q;

    logic              cyc_start;
    logic              cyc_wr;
    logic [ADDR_W-1:0] cyc_addr;
    logic [15:0]       cyc_wdata;
    logic              cyc_idle;
    logic              cyc_done;
    logic [15:0]       rd_word;
    logic [15:0]       exp_word;
    logic              settled;
    logic              word_ok;
    logic              at_limit;
    step_t             cur_step;

    assign cur_step  = seq_step(op_q, step_q, wdat_q);
    assign cyc_wr    = (st == SQ_WRITE);
    assign cyc_start = (st != SQ_IDLE) && cyc_idle && !pending;
    assign cyc_addr  = (cyc_wr && !cur_step.use_target) ? ADDR_W'(cur_step.key_addr) : tgt_q;
    assign cyc_wdata = cur_step.data;
    assign exp_word  = (op_q == OP_PROGRAM) ? wdat_q : 16'hFFFF;
    assign at_limit  = (poll_cnt == PC_LAST);

    flash_bus_cycle #(
        .ADDR_W (ADDR_W),
        .DATA_W (16),
        .CNT_W  (CNT_W)
    ) cyc_i (
        .clk      (clk),
        .rst      (rst),
        .start    (cyc_start),
        .wr       (cyc_wr),
        .addr     (cyc_addr),
        .wdata    (cyc_wdata),
        .t_setup  (t_setup),
        .t_pulse  (t_pulse),
        .t_hold   (t_hold),
        .dq_in    (fl_dq_in),
        .idle     (cyc_idle),
        .cyc_done (cyc_done),
        .rdata    (rd_word),
        .ce_n     (fl_ce_n),
        .we_n     (fl_we_n),
        .oe_n     (fl_oe_n),
        .bus_addr (fl_addr),
        .dq_out   (fl_dq_out),
        .dq_oe    (fl_dq_oe)
    );

    flash_poll_eval #(
        .DATA_W (16)
    ) eval_i (
        .toggle_mode (cfg_toggle),
        .rd_word     (rd_word),
        .exp_word    (exp_word),
        .prev_b6     (prev_b6),
        .have_prev   (have_prev),
        .settled     (settled),
        .word_ok     (word_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            op_q      <= OP_PROGRAM;
            tgt_q     <= '0;
            wdat_q    <= '0;
            step_q    <= '0;
            pending   <= 1'b0;
            prev_b6   <= 1'b0;
            have_prev <= 1'b0;
            poll_cnt  <= '0;
            conf_cnt  <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (cyc_start) pending <= 1'b1;
            else if (cyc_done) pending <= 1'b0;

            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        op_q   <= op_e'(req_op);
                        tgt_q  <= req_addr;
                        wdat_q <= req_data;
                        step_q <= '0;
                        st     <= SQ_WRITE;
                    end
                end
                SQ_WRITE: begin
                    if (cyc_done) begin
                        if (step_q == last_step(op_q)) begin
                            st        <= SQ_POLL;
                            poll_cnt  <= '0;
                            have_prev <= 1'b0;
                            conf_cnt  <= 1'b0;
                        end else begin
                            step_q <= step_q + 3'd1;
                        end
                    end
                end
                SQ_POLL: begin
                    if (cyc_done) begin
                        prev_b6   <= rd_word[6];
                        have_prev <= 1'b1;
                        poll_cnt  <= poll_cnt + 1'b1;
                        if (at_limit) begin
                            err_q <= 1'b1;
                            st    <= SQ_IDLE;
                        end else if (settled) begin
                            conf_cnt <= 1'b0;
                            st       <= SQ_CONFIRM;
                        end
                    end
                end
                default: begin
                    if (cyc_done) begin
                        prev_b6   <= rd_word[6];
                        have_prev <= 1'b1;
                        poll_cnt  <= poll_cnt + 1'b1;
                        if (word_ok && conf_cnt) begin
                            done_q <= 1'b1;
                            st     <= SQ_IDLE;
                        end else if (at_limit) begin
                            err_q <= 1'b1;
                            st    <= SQ_IDLE;
                        end else if (word_ok) begin
                            conf_cnt <= 1'b1;
                        end else begin
                            st <= SQ_POLL;
                        end
                    end
                end
            endcase
        end
    end

    assign req_ready = (st == SQ_IDLE);
    assign done      = done_q;
    assign err       = err_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic              fl_ce_n,
    input logic              fl_we_n,
    input logic              fl_oe_n,
    input logic              fl_dq_oe,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [15:0]       fl_dq_out
);

    // R4
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);

    // R4
    write_bus_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    // R4
    write_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> fl_dq_oe);

    // R5
    read_releases_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (!fl_dq_oe && !fl_ce_n));

    // R5
    no_double_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R10
    accept_goes_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n));

endmodule

bind flash_seq_top flash_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_dq_oe  (fl_dq_oe),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out)
);

// File: tb/flash_seq_top_tb.sv
module flash_seq_top_tb_top;

    localparam int AW  = 18;
    localparam int CW  = 4;
    localparam int LIM = 64;

    typedef struct packed {
        logic [1:0]  op;
        logic [17:0] addr;
        logic [15:0] data;
        logic        tog;
        logic [7:0]  busy;
        logic [7:0]  glitch;
        logic [3:0]  tsu;
        logic [3:0]  tpw;
        logic [3:0]  th;
        logic        exp_err;
        logic [7:0]  exp_reads;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 18'h01234, 16'h1357, 1'b0, 8'd3,   8'd0, 4'd1, 4'd1, 4'd1, 1'b0, 8'd6},
        '{2'd0, 18'h3FFFF, 16'h00FF, 1'b0, 8'd0,   8'd0, 4'd2, 4'd3, 4'd1, 1'b0, 8'd3},
        '{2'd1, 18'h05800, 16'h0000, 1'b0, 8'd5,   8'd2, 4'd1, 4'd2, 4'd0, 1'b0, 8'd8},
        '{2'd2, 18'h18000, 16'h0000, 1'b1, 8'd4,   8'd0, 4'd0, 4'd1, 4'd2, 1'b0, 8'd8},
        '{2'd3, 18'h00777, 16'h0000, 1'b1, 8'd3,   8'd0, 4'd1, 4'd1, 4'd1, 1'b0, 8'd6},
        '{2'd0, 18'h00010, 16'hA5C3, 1'b1, 8'd0,   8'd0, 4'd1, 4'd1, 4'd1, 1'b0, 8'd4},
        '{2'd1, 18'h00800, 16'h0000, 1'b0, 8'd2,   8'd4, 4'd1, 4'd1, 4'd1, 1'b0, 8'd7},
        '{2'd0, 18'h2AAA0, 16'h4242, 1'b0, 8'd255, 8'd0, 4'd1, 4'd1, 4'd1, 1'b1, 8'd64},
        '{2'd2, 18'h10000, 16'h0000, 1'b0, 8'd1,   8'd0, 4'd3, 4'd1, 4'd3, 1'b0, 8'd4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          cfg_toggle = 1'b0;
    logic [CW-1:0] t_setup = 4'd1;
    logic [CW-1:0] t_pulse = 4'd1;
    logic [CW-1:0] t_hold = 4'd1;
    logic          done;
    logic          err;
    logic          fl_ce_n;
    logic          fl_we_n;
    logic          fl_oe_n;
    logic [AW-1:0] fl_addr;
    logic [15:0]   fl_dq_out;
    logic          fl_dq_oe;
    logic [15:0]   fl_dq_in = 16'h0000;

    always #10 clk = ~clk;

    flash_seq_top #(.ADDR_W(AW), .CNT_W(CW), .POLL_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .cfg_toggle(cfg_toggle), .t_setup(t_setup), .t_pulse(t_pulse),
        .t_hold(t_hold), .done(done), .err(err), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash device model ----------------
    logic [15:0]   m_exp = 16'hFFFF;
    int            m_busy = 0;
    int            m_glitch = 0;
    int            m_su = 1, m_pw = 1, m_hd = 1;
    int            wr_n = 0;
    int            rd_n = 0;
    int            tim_bad = 0;
    int            bus_bad = 0;
    logic [AW-1:0] log_a [0:7];
    logic [15:0]   log_d [0:7];

    logic          p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    int            su_run = 0, pw_run = 0, hd_run = 0;
    logic          in_hold = 1'b0;
    logic [AW-1:0] cap_a;
    logic [15:0]   cap_d;

    always @(negedge clk) begin
        if (rst) begin
            p_ce = 1'b1; p_we = 1'b1; p_oe = 1'b1; in_hold = 1'b0;
        end else begin
            if (p_ce && !fl_ce_n) begin su_run = 0; in_hold = 1'b0; end
            if (!fl_ce_n && fl_we_n && fl_oe_n && !in_hold && p_we && p_oe) su_run++;
            if (p_we && !fl_we_n) begin
                if (su_run != m_su) tim_bad++;
                cap_a = fl_addr; cap_d = fl_dq_out; pw_run = 0;
            end
            if (!fl_we_n) begin
                pw_run++;
                if (fl_addr != cap_a || fl_dq_out != cap_d || !fl_dq_oe) bus_bad++;
            end
            if (!p_we && fl_we_n) begin
                if (pw_run != m_pw) tim_bad++;
                if (wr_n < 8) begin log_a[wr_n] = cap_a; log_d[wr_n] = cap_d; end
                wr_n++;
                in_hold = 1'b1; hd_run = 0;
            end
            if (in_hold && !fl_ce_n && fl_we_n) hd_run++;
            if (!p_ce && fl_ce_n && in_hold) begin
                if (hd_run != m_hd) tim_bad++;
                in_hold = 1'b0;
            end
            if (!fl_oe_n && (fl_dq_oe || !fl_we_n)) bus_bad++;
            if (p_oe && !fl_oe_n) begin
                rd_n++;
                if (fl_addr != req_addr) bus_bad++;
                if (rd_n == m_glitch) fl_dq_in = m_exp ^ 16'h0001;
                else if (rd_n <= m_busy)
                    fl_dq_in = {m_exp[15:8], ~m_exp[7], rd_n[0], m_exp[5:0]};
                else fl_dq_in = m_exp;
            end
            p_ce = fl_ce_n; p_we = fl_we_n; p_oe = fl_oe_n;
        end
    end

    // Expected command sequence from R1/R2.
    task automatic exp_write(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                             input int i, output logic [AW-1:0] ea, output logic [15:0] ed);
        if (op == 2'd0) begin
            case (i)
                0: begin ea = 18'h05555; ed = 16'h00AA; end
                1: begin ea = 18'h02AAA; ed = 16'h0055; end
                2: begin ea = 18'h05555; ed = 16'h00A0; end
                default: begin ea = a; ed = d; end
            endcase
        end else begin
            case (i)
                0, 3: begin ea = 18'h05555; ed = 16'h00AA; end
                1, 4: begin ea = 18'h02AAA; ed = 16'h0055; end
                2: begin ea = 18'h05555; ed = 16'h0080; end
                default: begin
                    if (op == 2'd1) begin ea = a; ed = 16'h0030; end
                    else if (op == 2'd2) begin ea = a; ed = 16'h0050; end
                    else begin ea = 18'h05555; ed = 16'h0010; end
                end
            endcase
        end
    endtask

    task automatic run_vec(input vec_t v, input int k);
        int nw;
        int guard;
        logic saw_ready;
        logic [AW-1:0] ea;
        logic [15:0] ed;
        logic got_done, got_err;
        m_exp    = (v.op == 2'd0) ? v.data : 16'hFFFF;
        m_busy   = v.busy;
        m_glitch = v.glitch;
        m_su = (v.tsu == 0) ? 1 : int'(v.tsu);
        m_pw = (v.tpw == 0) ? 1 : int'(v.tpw);
        m_hd = (v.th == 0) ? 1 : int'(v.th);
        wr_n = 0; rd_n = 0; tim_bad = 0; bus_bad = 0;
        nw = (v.op == 2'd0) ? 4 : 6;
        @(negedge clk);
        cfg_toggle = v.tog; t_setup = v.tsu; t_pulse = v.tpw; t_hold = v.th;
        req_op = v.op; req_addr = v.addr; req_data = v.data; req_valid = 1'b1;
        @(negedge clk);
        // R10: raise a different request while busy; it must not be taken.
        req_op = 2'd3;
        saw_ready = 1'b0;
        for (int c = 0; c < 10; c++) begin
            if (req_ready) saw_ready = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(!saw_ready, $sformatf("R10 vec%0d ready while busy", k), saw_ready, 0);
        got_done = 1'b0; got_err = 1'b0; guard = 0;
        while (!got_done && !got_err && guard < 20000) begin
            @(negedge clk);
            got_done = done; got_err = err; guard++;
        end
        // R8 / R9
        check(got_err == v.exp_err && got_done == !v.exp_err,
              $sformatf("R8 R9 vec%0d outcome done/err", k), {got_done, got_err}, {!v.exp_err, v.exp_err});
        // R6 R7 R8 R9: status read count follows from the device busy profile
        check(rd_n == v.exp_reads, $sformatf("R6 R7 vec%0d read count", k), rd_n, v.exp_reads);
        repeat (3) @(negedge clk);
        // R1 R2 R10
        check(wr_n == nw, $sformatf("R1 R2 R10 vec%0d write count", k), wr_n, nw);
        for (int i = 0; i < nw && i < 8; i++) begin
            exp_write(v.op, v.addr, v.data, i, ea, ed);
            check(log_a[i] == ea && log_d[i] == ed,
                  $sformatf("R1 R2 vec%0d write%0d addr/data", k, i),
                  {log_a[i], log_d[i]}, {ea, ed});
        end
        check(tim_bad == 0, $sformatf("R3 vec%0d phase lengths", k), tim_bad, 0);
        check(bus_bad == 0, $sformatf("R4 R5 vec%0d bus discipline", k), bus_bad, 0);
        check(req_ready && fl_ce_n, $sformatf("R10 vec%0d back to idle", k), {req_ready, fl_ce_n}, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && req_ready && !done && !err,
              "R11 reset outputs", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, req_ready, done, err},
              7'b1110100);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R11: reset in the middle of a write sequence returns the bus to idle.
        req_op = 2'd1; req_addr = 18'h00400; req_valid = 1'b1;
        t_setup = 4'd2; t_pulse = 4'd2; t_hold = 4'd2;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && req_ready,
              "R11 reset mid-operation", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, req_ready}, 5'b11101);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle with no request keeps the bus quiet.
        wr_n = 0; rd_n = 0;
        repeat (20) @(negedge clk);
        check(wr_n == 0 && rd_n == 0 && fl_ce_n, "R10 idle no activity", wr_n + rd_n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule